// File: doc/BRIEF.md
# Shadow Store/Recall Sequencer

This controller sequences whole-array transfers between a working SRAM and its nonvolatile shadow copy. A STORE copies the working array into the shadow. A RECALL copies the shadow back. Three sources can start a STORE: an active-low request pin, the rising edge of a low-supply flag (automatic store), and a one-cycle pulse from a software command decoder. A RECALL starts either when the supply recovers or on a software recall pulse. The transfer engine is abstract: the sequencer times each transfer with a down-counter and marks it with start and done pulses.

While a transfer runs, reads and writes to the array are blocked. A STORE drives an open-drain busy line low. Pin-requested and automatic stores are skipped when nothing has been written since the last transfer. A pin request first opens a grace window, in which reads continue and a write already in flight may finish. After any STORE the array stays locked until the request pin reads high. Automatic store can be switched off and on by command. Its setting is copied into the shadow only by a manual store, and the supply-recovery recall restores it from there.

Top module: `shadowXferCtl`

## Requirements
- R1: A dirty flag is set by `sramWrDone` and cleared when any STORE or RECALL ends. A pin request or a supply-low rising edge while the flag is clear starts no STORE: `busyOutEn` stays 0 and `xferStart` stays 0.
- R2: A high-to-low change of `hwReqN` while idle and dirty opens a grace window of GRACE_CYC cycles. During it `rdInhibit` = 0, `wrInhibit` = 1 and `busyOutEn` = 0, and the STORE follows the window. `wrInhibit` is 1 whenever `hwReqN` is low.
- R3: A STORE holds `busyOutEn` = 1 and `busyOutVal` = 0 for exactly STORE_CYC cycles. `xferStart` pulses for one cycle in its first cycle. `xferDone` pulses for one cycle in the first cycle after it. `xferIsRecall` stays 0.
- R4: After a STORE, `rdInhibit` and `wrInhibit` stay 1 until `hwReqN` is sampled high. They fall in the cycle after that sample.
- R5: A `swStorePulse` while idle starts a STORE in the next cycle, with no grace window, whether or not the dirty flag is set.
- R6: A rising edge of `supplyLow` while idle, dirty and with automatic store on starts a STORE in the next cycle.
- R7: While `supplyLow` = 1, `rdInhibit` and `wrInhibit` are 1, including in and right after reset.
- R8: After reset, and after every period of `supplyLow` = 1, a RECALL starts once `supplyLow` = 0 and the sequencer is idle. `xferIsRecall` is 1 for PWRUP_RECALL_CYC cycles, with reads and writes blocked and `busyOutEn` = 0. It takes precedence over a store pulse in the same cycle.
- R9: A `swRecallPulse` while idle with `supplyLow` = 0 runs a RECALL of SW_RECALL_CYC cycles. That RECALL clears the dirty flag.
- R10: Automatic store is on after reset. `autoOffReq` and `autoOnReq` change the live setting. A manual (pin or software) STORE copies the live setting into the shadow. A supply-recovery RECALL reloads the live setting from the shadow.
- R11: Triggers arriving in the same cycle merge into one STORE. If a software or automatic trigger is among them, the STORE starts without a grace window. Triggers that arrive while a grace window, transfer or lock is active are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwReqN | input | 1 | Store request pin level, active low |
| supplyLow | input | 1 | Low-supply comparator flag |
| swStorePulse | input | 1 | One-cycle software store command |
| swRecallPulse | input | 1 | One-cycle software recall command |
| sramWrDone | input | 1 | One-cycle pulse for each completed array write |
| autoOffReq | input | 1 | One-cycle command that disables automatic store |
| autoOnReq | input | 1 | One-cycle command that enables automatic store |
| busyOutEn | output | 1 | Drive enable of the open-drain busy line |
| busyOutVal | output | 1 | Value driven when enabled, always 0 |
| rdInhibit | output | 1 | Blocks array reads |
| wrInhibit | output | 1 | Blocks new array writes |
| xferStart | output | 1 | One-cycle pulse at the start of a transfer |
| xferDone | output | 1 | One-cycle pulse after a transfer ends |
| xferIsRecall | output | 1 | High while a RECALL runs |

## Verification
The STORE path is driven once from each trigger on its own, each with the dirty flag set and again with it clear. This separates the dirty-flag gating of pin and automatic requests from the unconditional software store, and exposes the grace window, which only the pin path opens. A software pulse and a pin fall in the same cycle, plus a repeated pulse during a running STORE, show whether merging and dropping yield exactly one STORE of the right length. Power cycles with automatic store switched off, both with and without a manual store in between, show whether the reloaded setting comes from the shadow copy rather than from the live register.

// File: rtl/shadowPkg.sv
package shadowPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_GRACE,
    S_STORE,
    S_LOCK,
    S_RECALL
  } seqState_t;

  typedef enum logic [1:0] {
    D_GRACE,
    D_STORE,
    D_PWRREC,
    D_SWREC
  } durSel_t;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic    loadCnt;
    durSel_t durSel;
    logic    stepCnt;
    logic    clrDirty;
    logic    saveAuto;
    logic    restoreAuto;
    logic    clrRecallNeed;
  } ctlStrobe_t;

endpackage

// File: rtl/shadowDp.sv
module shadowDp
  import shadowPkg::*;
#(
  parameter int GRACE_CYC        = 4,
  parameter int STORE_CYC        = 8,
  parameter int PWRUP_RECALL_CYC = 6,
  parameter int SW_RECALL_CYC    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       sramWrDone,
  input  logic       autoOffReq,
  input  logic       autoOnReq,
  input  logic       supplyLow,
  output logic       cntZero,
  output logic       dirty,
  output logic       autoEn,
  output logic       recallNeed
);

  // durations are clamped to at least one cycle
  localparam int GRACE_N  = (GRACE_CYC < 1) ? 1 : GRACE_CYC;
  localparam int STORE_N  = (STORE_CYC < 1) ? 1 : STORE_CYC;
  localparam int PWRREC_N = (PWRUP_RECALL_CYC < 1) ? 1 : PWRUP_RECALL_CYC;
  localparam int SWREC_N  = (SW_RECALL_CYC < 1) ? 1 : SW_RECALL_CYC;
  localparam int MAX_A    = (GRACE_N > STORE_N) ? GRACE_N : STORE_N;
  localparam int MAX_B    = (PWRREC_N > SWREC_N) ? PWRREC_N : SWREC_N;
  localparam int MAX_N    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_N + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic             autoSaved;

  always_comb begin
    case (strobe.durSel)
      D_GRACE:  loadVal = CNT_W'(GRACE_N - 1);
      D_STORE:  loadVal = CNT_W'(STORE_N - 1);
      D_PWRREC: loadVal = CNT_W'(PWRREC_N - 1);
      default:  loadVal = CNT_W'(SWREC_N - 1);
    endcase
  end

  // phase timer: a loaded value N-1 gives a phase of N cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.loadCnt) begin
      cnt <= loadVal;
    end else if (strobe.stepCnt && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  // written-since-last-transfer flag; clearing wins over a late write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirty <= 1'b0;
    end else if (strobe.clrDirty) begin
      dirty <= 1'b0;
    end else if (sramWrDone) begin
      dirty <= 1'b1;
    end
  end

  // automatic store setting: live copy and shadow copy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoEn    <= 1'b1;
      autoSaved <= 1'b1;
    end else begin
      if (strobe.saveAuto) begin
        autoSaved <= autoEn;
      end
      if (strobe.restoreAuto) begin
        autoEn <= autoSaved;
      end else if (autoOffReq) begin
        autoEn <= 1'b0;
      end else if (autoOnReq) begin
        autoEn <= 1'b1;
      end
    end
  end

  // a supply-recovery recall is owed after reset and after any low period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recallNeed <= 1'b1;
    end else if (supplyLow) begin
      recallNeed <= 1'b1;
    end else if (strobe.clrRecallNeed) begin
      recallNeed <= 1'b0;
    end
  end

  a_r1_dirty_clears : assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrDirty |=> !dirty);

  a_r10_restore_from_shadow : assert property (@(posedge clk) disable iff (!rstN)
    strobe.restoreAuto |=> (autoEn == $past(autoSaved)));

endmodule

// File: rtl/shadowCtl.sv
module shadowCtl
  import shadowPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwReqN,
  input  logic       supplyLow,
  input  logic       swStorePulse,
  input  logic       swRecallPulse,
  input  logic       cntZero,
  input  logic       dirty,
  input  logic       autoEn,
  input  logic       recallNeed,
  output ctlStrobe_t strobe,
  output logic       busyOutEn,
  output logic       rdInhibit,
  output logic       wrInhibit,
  output logic       xferStart,
  output logic       xferDone,
  output logic       xferIsRecall
);

  seqState_t state, nxt;
  logic prevHwN, prevLow;
  logic isManual, manualNxt;
  logic isPwrRec, pwrRecNxt;
  logic startSet, doneSet;
  logic xferStartQ, xferDoneQ;
  logic hwTrig, autoTrig, swTrig;

  assign hwTrig   = prevHwN & ~hwReqN & dirty & ~supplyLow;
  assign autoTrig = supplyLow & ~prevLow & autoEn & dirty;
  assign swTrig   = swStorePulse & ~supplyLow;

  always_comb begin
    nxt       = state;
    strobe    = '0;
    strobe.durSel = D_GRACE;
    startSet  = 1'b0;
    doneSet   = 1'b0;
    manualNxt = isManual;
    pwrRecNxt = isPwrRec;
    case (state)
      S_IDLE: begin
        if (recallNeed && !supplyLow) begin
          nxt                  = S_RECALL;
          strobe.loadCnt       = 1'b1;
          strobe.durSel        = D_PWRREC;
          strobe.clrRecallNeed = 1'b1;
          pwrRecNxt            = 1'b1;
          startSet             = 1'b1;
        end else if (swTrig || autoTrig) begin
          nxt            = S_STORE;
          strobe.loadCnt = 1'b1;
          strobe.durSel  = D_STORE;
          manualNxt      = swTrig | hwTrig;
          startSet       = 1'b1;
        end else if (hwTrig) begin
          nxt            = S_GRACE;
          strobe.loadCnt = 1'b1;
          strobe.durSel  = D_GRACE;
          manualNxt      = 1'b1;
        end else if (swRecallPulse && !supplyLow) begin
          nxt            = S_RECALL;
          strobe.loadCnt = 1'b1;
          strobe.durSel  = D_SWREC;
          pwrRecNxt      = 1'b0;
          startSet       = 1'b1;
        end
      end
      S_GRACE: begin
        if (cntZero) begin
          nxt            = S_STORE;
          strobe.loadCnt = 1'b1;
          strobe.durSel  = D_STORE;
          startSet       = 1'b1;
        end else begin
          strobe.stepCnt = 1'b1;
        end
      end
      S_STORE: begin
        if (cntZero) begin
          nxt             = S_LOCK;
          strobe.clrDirty = 1'b1;
          strobe.saveAuto = isManual;
          doneSet         = 1'b1;
        end else begin
          strobe.stepCnt = 1'b1;
        end
      end
      S_LOCK: begin
        if (hwReqN) begin
          nxt = S_IDLE;
        end
      end
      S_RECALL: begin
        if (cntZero) begin
          nxt                = S_IDLE;
          strobe.clrDirty    = 1'b1;
          strobe.restoreAuto = isPwrRec;
          doneSet            = 1'b1;
        end else begin
          strobe.stepCnt = 1'b1;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      prevHwN    <= 1'b1;
      prevLow    <= 1'b1;
      isManual   <= 1'b0;
      isPwrRec   <= 1'b0;
      xferStartQ <= 1'b0;
      xferDoneQ  <= 1'b0;
    end else begin
      state      <= nxt;
      prevHwN    <= hwReqN;
      prevLow    <= supplyLow;
      isManual   <= manualNxt;
      isPwrRec   <= pwrRecNxt;
      xferStartQ <= startSet;
      xferDoneQ  <= doneSet;
    end
  end

  assign busyOutEn    = (state == S_STORE);
  assign xferIsRecall = (state == S_RECALL);
  assign rdInhibit    = supplyLow | (state == S_STORE) | (state == S_LOCK) |
                        (state == S_RECALL);
  assign wrInhibit    = rdInhibit | ~hwReqN | (state == S_GRACE);
  assign xferStart    = xferStartQ;
  assign xferDone     = xferDoneQ;

  a_r4_lock_until_release : assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LOCK && !hwReqN) |=> (state == S_LOCK));

  a_r3_done_after_busy : assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOutEn) |-> xferDone);

  a_r11_single_start : assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);

  a_r2_grace_leads_store : assert property (@(posedge clk) disable iff (!rstN)
    (state == S_GRACE && cntZero) |=> busyOutEn);

endmodule

// File: rtl/shadowXferCtl.sv
module shadowXferCtl
  import shadowPkg::*;
#(
  parameter int GRACE_CYC        = 4,
  parameter int STORE_CYC        = 8,
  parameter int PWRUP_RECALL_CYC = 6,
  parameter int SW_RECALL_CYC    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic hwReqN,
  input  logic supplyLow,
  input  logic swStorePulse,
  input  logic swRecallPulse,
  input  logic sramWrDone,
  input  logic autoOffReq,
  input  logic autoOnReq,
  output logic busyOutEn,
  output logic busyOutVal,
  output logic rdInhibit,
  output logic wrInhibit,
  output logic xferStart,
  output logic xferDone,
  output logic xferIsRecall
);

  ctlStrobe_t strobe;
  logic cntZero, dirty, autoEn, recallNeed;

  shadowCtl uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .hwReqN       (hwReqN),
    .supplyLow    (supplyLow),
    .swStorePulse (swStorePulse),
    .swRecallPulse(swRecallPulse),
    .cntZero      (cntZero),
    .dirty        (dirty),
    .autoEn       (autoEn),
    .recallNeed   (recallNeed),
    .strobe       (strobe),
    .busyOutEn    (busyOutEn),
    .rdInhibit    (rdInhibit),
    .wrInhibit    (wrInhibit),
    .xferStart    (xferStart),
    .xferDone     (xferDone),
    .xferIsRecall (xferIsRecall)
  );

  shadowDp #(
    .GRACE_CYC       (GRACE_CYC),
    .STORE_CYC       (STORE_CYC),
    .PWRUP_RECALL_CYC(PWRUP_RECALL_CYC),
    .SW_RECALL_CYC   (SW_RECALL_CYC)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sramWrDone(sramWrDone),
    .autoOffReq(autoOffReq),
    .autoOnReq (autoOnReq),
    .supplyLow (supplyLow),
    .cntZero   (cntZero),
    .dirty     (dirty),
    .autoEn    (autoEn),
    .recallNeed(recallNeed)
  );

  // open-drain busy: only ever pulls low, a pull-up supplies the high level
  assign busyOutVal = 1'b0;

  a_r7_supply_inhibit : assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |-> (rdInhibit && wrInhibit));

  a_r3_busy_inhibits : assert property (@(posedge clk) disable iff (!rstN)
    busyOutEn |-> (rdInhibit && wrInhibit && !xferIsRecall));

  a_r1_done_leaves_clean : assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> !dirty);

endmodule

// File: tb/sim_shadowXferCtl.sv
module sim_shadowXferCtl;

  localparam int G  = 4;
  localparam int S  = 8;
  localparam int PW = 6;
  localparam int SR = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hwReqN = 1'b1, supplyLow = 1'b1, swStorePulse = 1'b0, swRecallPulse = 1'b0;
  logic sramWrDone = 1'b0, autoOffReq = 1'b0, autoOnReq = 1'b0;
  logic busyOutEn, busyOutVal, rdInhibit, wrInhibit, xferStart, xferDone, xferIsRecall;

  int nChecks = 0;
  int nFails  = 0;
  int cBusy, cStart, cDone, cRec, cGrace, cLock, cRd, cWr, cVal;
  int lastRd, lastWr;

  always #4 clk = ~clk;  // 125 MHz

  shadowXferCtl #(
    .GRACE_CYC(G), .STORE_CYC(S), .PWRUP_RECALL_CYC(PW), .SW_RECALL_CYC(SR)
  ) u0 (
    .clk(clk), .rstN(rstN), .hwReqN(hwReqN), .supplyLow(supplyLow),
    .swStorePulse(swStorePulse), .swRecallPulse(swRecallPulse),
    .sramWrDone(sramWrDone), .autoOffReq(autoOffReq), .autoOnReq(autoOnReq),
    .busyOutEn(busyOutEn), .busyOutVal(busyOutVal), .rdInhibit(rdInhibit),
    .wrInhibit(wrInhibit), .xferStart(xferStart), .xferDone(xferDone),
    .xferIsRecall(xferIsRecall)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // sample n negedges; one-cycle command inputs are cleared after the first
  task automatic window(input int n);
    cBusy = 0; cStart = 0; cDone = 0; cRec = 0; cGrace = 0;
    cLock = 0; cRd = 0; cWr = 0; cVal = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cBusy  += int'(busyOutEn);
      cStart += int'(xferStart);
      cDone  += int'(xferDone);
      cRec   += int'(xferIsRecall);
      cRd    += int'(rdInhibit);
      cWr    += int'(wrInhibit);
      cVal   += int'(busyOutVal);
      cGrace += int'(wrInhibit && !rdInhibit && !busyOutEn);
      cLock  += int'(rdInhibit && !busyOutEn && !xferIsRecall && !supplyLow);
      lastRd = int'(rdInhibit);
      lastWr = int'(wrInhibit);
      if (i == 0) begin
        swStorePulse = 1'b0; swRecallPulse = 1'b0; sramWrDone = 1'b0;
        autoOffReq = 1'b0; autoOnReq = 1'b0;
      end
    end
  endtask

  task automatic tReset;
    window(2);
    chk("R7 reset rdInhibit", cRd, 2);
    chk("R7 reset wrInhibit", cWr, 2);
    chk("R3 reset busy", cBusy, 0);
    chk("R3 reset start", cStart, 0);
  endtask

  task automatic tPowerUpRecall;
    supplyLow = 1'b0;
    window(PW + 3);
    chk("R8 recall length", cRec, PW);
    chk("R8 recall blocks reads", cRd, PW);
    chk("R8 recall no busy", cBusy, 0);
    chk("R8 recall start", cStart, 1);
    chk("R8 recall done", cDone, 1);
  endtask

  task automatic tHwClean;
    hwReqN = 1'b0;
    window(G + S + 4);
    chk("R1 clean pin no busy", cBusy, 0);
    chk("R1 clean pin no start", cStart, 0);
    chk("R2 pin low blocks writes", cWr, G + S + 4);
    hwReqN = 1'b1;
    window(2);
  endtask

  task automatic tHwDirty;
    sramWrDone = 1'b1;
    window(2);
    hwReqN = 1'b0;
    window(G + S + 5);
    chk("R2 grace length", cGrace, G);
    chk("R3 store length", cBusy, S);
    chk("R3 busy value low", cVal, 0);
    chk("R3 one start", cStart, 1);
    chk("R3 one done", cDone, 1);
    chk("R4 locked while pin low", cLock, 5);
    hwReqN = 1'b1;
    window(1);
    chk("R4 reads free after release", lastRd, 0);
    chk("R4 writes free after release", lastWr, 0);
    window(1);
  endtask

  task automatic tSwStore;
    swStorePulse = 1'b1;
    window(S + 3);
    chk("R5 clean sw store length", cBusy, S);
    chk("R5 no grace", cGrace, 0);
    chk("R5 one start", cStart, 1);
  endtask

  task automatic tAutoStore;
    sramWrDone = 1'b1;
    window(2);
    supplyLow = 1'b1;
    window(S + 4);
    chk("R6 auto store length", cBusy, S);
    chk("R7 supply low blocks reads", cRd, S + 4);
    chk("R7 supply low blocks writes", cWr, S + 4);
    supplyLow = 1'b0;
    window(PW + 3);
    chk("R8 recall after low", cRec, PW);
    supplyLow = 1'b1;
    window(10);
    chk("R6 clean auto skipped", cBusy, 0);
    supplyLow = 1'b0;
    window(PW + 3);
    chk("R8 recall after clean low", cRec, PW);
  endtask

  task automatic lowCycleExpect(input string tag, input int expBusy);
    sramWrDone = 1'b1;
    window(2);
    supplyLow = 1'b1;
    window(S + 4);
    chk(tag, cBusy, expBusy);
    supplyLow = 1'b0;
    window(PW + 3);
  endtask

  task automatic tAutoCfg;
    autoOffReq = 1'b1;
    window(2);
    lowCycleExpect("R10 auto off skips store", 0);
    lowCycleExpect("R10 setting reloaded from shadow (on)", S);
    autoOffReq = 1'b1;
    window(2);
    swStorePulse = 1'b1;
    window(S + 3);
    lowCycleExpect("R10 auto off after manual save", 0);
    lowCycleExpect("R10 saved off survives power cycle", 0);
    autoOnReq = 1'b1;
    window(2);
    swStorePulse = 1'b1;
    window(S + 3);
    lowCycleExpect("R10 auto on again", S);
  endtask

  task automatic tSwRecall;
    sramWrDone = 1'b1;
    window(2);
    swRecallPulse = 1'b1;
    window(SR + 3);
    chk("R9 sw recall length", cRec, SR);
    chk("R9 sw recall no busy", cBusy, 0);
    hwReqN = 1'b0;
    window(G + S + 3);
    chk("R9 recall cleared dirty", cBusy, 0);
    hwReqN = 1'b1;
    window(2);
  endtask

  task automatic tMerge;
    int totBusy, totStart;
    sramWrDone = 1'b1;
    window(2);
    hwReqN = 1'b0;
    swStorePulse = 1'b1;
    window(S + 3);
    chk("R11 merged store length", cBusy, S);
    chk("R11 merged single start", cStart, 1);
    chk("R11 merged no grace", cGrace, 0);
    swStorePulse = 1'b1;
    window(3);
    chk("R11 pulse in lock dropped", cBusy, 0);
    hwReqN = 1'b1;
    window(2);
    swStorePulse = 1'b1;
    window(3);
    totBusy = cBusy; totStart = cStart;
    swStorePulse = 1'b1;
    window(S + 3);
    totBusy += cBusy; totStart += cStart;
    chk("R11 pulse during store dropped", totBusy, S);
    chk("R11 single start while busy", totStart, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tPowerUpRecall();
    tHwClean();
    tHwDirty();
    tSwStore();
    tAutoStore();
    tAutoCfg();
    tSwRecall();
    tMerge();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule